// File: doc/BRIEF.md
# Working-Set Clock Victim Selector

This block picks the slot to be reused when a page fault needs room among a small, fixed set of resident page slots. The slots form a ring visited by a rotating hand. Each slot keeps a valid flag, a referenced flag, a dirty flag, a pending write-back flag and a last-use timestamp. Memory accesses set the referenced flag, and writes also set the dirty flag. A timer tick advances a time base and restamps every slot whose referenced flag is set. A load input installs a fresh page into a slot.

An eviction request starts a sweep that inspects one slot per cycle at the hand. A referenced slot has its flag cleared and its stamp refreshed, and so gets a second chance. A slot that is unreferenced and older than the age threshold lies outside the working set. If it is clean it is chosen at once. If it is dirty, a write-back request goes out and the sweep moves on, with a limit on the number of requests in one sweep. After a full lap with no choice, the selector waits for a pending write-back to finish and then takes that slot. If no write-back is pending, it takes the slot under the hand. The slot count must be a power of two.

FSM states are `ST_IDLE`, `ST_SCAN`, `ST_LOOP_END` and `ST_WAIT_WB`. The transitions are:
- idle→scan when a request arrives;
- scan→idle when a victim is chosen;
- scan→loop-end when the eighth step completes with no choice;
- loop-end→idle when a write-back completes in that cycle, or when nothing is pending (the hand slot is chosen);
- loop-end→wait when a write-back is pending;
- wait→idle when a write-back completes.

Top module: `wsclock_victim_sel`

## Requirements
- R1: After reset every slot is invalid, the hand is at slot 0, time is 0, `busy_o` is 0 and no pulse is driven.
- R2: A load makes the slot valid with referenced, dirty and pending clear and stamps it with the current time. An access to a valid slot sets referenced, and a write access also sets dirty. An access to an invalid slot has no effect. Within one cycle a load overrides every other update to the same slot.
- R3: A tick advances the time by one (16-bit wrap). Every slot whose referenced flag was set before the edge gets the new time as its stamp.
- R4: During a sweep, an invalid slot at the hand is chosen at once.
- R5: A valid referenced slot at the hand has referenced cleared, its stamp set to the current time, and the hand moves one step. Each sweep step takes one cycle.
- R6: A valid, unreferenced, clean slot whose age (time minus stamp, mod 2^16) exceeds `TAU` is chosen. The choice appears as a one-cycle `victim_valid_o` with `victim_idx_o`, and the hand then points one past the victim. The selector returns to idle.
- R7: An unreferenced slot with age ≤ `TAU` is passed over unchanged.
- R8: An old, dirty, unreferenced slot is passed over. If it is not already pending and fewer than `WB_CAP` requests have gone out in this sweep, a one-cycle `wb_req_o` is raised with `wb_idx_o` equal to that slot, and the slot is marked pending.
- R9: After eight steps with no choice and no pending write-back, the slot under the hand is chosen.
- R10: After eight steps with a pending write-back, the selector waits. The slot named by the next `wb_done_i` is chosen in that cycle.
- R11: `wb_done_i` clears the dirty and pending flags of slot `wb_done_idx_i` in any state.
- R12: `evict_req_i` has no effect while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer tick |
| load_en_i | input | 1 | Install a page in a slot |
| load_idx_i | input | 3 | Slot being loaded |
| acc_en_i | input | 1 | Memory access to a slot |
| acc_idx_i | input | 3 | Slot accessed |
| acc_wr_i | input | 1 | Access is a write |
| evict_req_i | input | 1 | Request a victim |
| wb_done_i | input | 1 | A write-back finished |
| wb_done_idx_i | input | 3 | Slot whose write-back finished |
| victim_valid_o | output | 1 | One-cycle victim strobe |
| victim_idx_o | output | 3 | Chosen slot |
| wb_req_o | output | 1 | One-cycle write-back request |
| wb_idx_o | output | 3 | Slot to write back |
| busy_o | output | 1 | A sweep is in progress |

## Verification
Several properties are checked on every cycle:
- the time base steps exactly on a tick;
- a load leaves its slot valid and unreferenced;
- a write-back completion leaves its slot clean;
- victim and write-back strobes appear only in sweeping states;
- the per-sweep request count never exceeds its cap;
- the hand moves exactly one step on every scan cycle that chooses nothing;
- the wait state holds until a completion arrives.

Only the bench's scenarios show which slot wins a given mix of reference, dirty and age states. They also show the second-chance refresh, the lap-end fallbacks, the cap being reached mid-sweep, and ticks interleaved with accesses. A behavioural model compares every output on every cycle to cover these.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SCAN     = 2'd1,
        ST_LOOP_END = 2'd2,
        ST_WAIT_WB  = 2'd3
    } sweep_state_e;
endpackage

// File: rtl/wsc_timebase.sv
module wsc_timebase #(
    parameter int TS_W = 16,
    parameter int TAU  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic [TS_W-1:0] stamp_i,
    output logic [TS_W-1:0] now_o,
    output logic            old_o
);
    logic [TS_W-1:0] now_q;
    logic [TS_W-1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) now_q <= '0;
        else if (tick_i) now_q <= now_q + 1'b1;
    end

    // modular subtraction keeps the age right across counter wrap
    assign age   = now_q - stamp_i;
    assign old_o = age > TS_W'(TAU);
    assign now_o = now_q;

    AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> now_q == TS_W'($past(now_q) + 1'b1)); // R3
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(now_q)); // R3
endmodule

// File: rtl/wsc_slot_array.sv
module wsc_slot_array #(
    parameter int NSLOT = 8,
    parameter int TS_W  = 16,
    localparam int IDX_W = $clog2(NSLOT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [TS_W-1:0]             now_i,
    input  logic                        tick_i,
    input  logic                        ld_en_i,
    input  logic [IDX_W-1:0]            ld_idx_i,
    input  logic                        acc_en_i,
    input  logic [IDX_W-1:0]            acc_idx_i,
    input  logic                        acc_wr_i,
    input  logic                        clr_en_i,
    input  logic [IDX_W-1:0]            clr_idx_i,
    input  logic                        evict_en_i,
    input  logic [IDX_W-1:0]            evict_idx_i,
    input  logic                        wbset_en_i,
    input  logic [IDX_W-1:0]            wbset_idx_i,
    input  logic                        wbdone_en_i,
    input  logic [IDX_W-1:0]            wbdone_idx_i,
    output logic [NSLOT-1:0]            valid_o,
    output logic [NSLOT-1:0]            ref_o,
    output logic [NSLOT-1:0]            dirty_o,
    output logic [NSLOT-1:0]            pend_o,
    output logic [NSLOT-1:0][TS_W-1:0]  stamp_o
);
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic [IDX_W-1:0] SI = IDX_W'(s);
        logic            v_q, r_q, d_q, p_q;
        logic [TS_W-1:0] t_q;
        logic            v_n, r_n, d_n, p_n;
        logic [TS_W-1:0] t_n;

        // update order: sweep, eviction, write-back marks, tick, completion, access, load
        always_comb begin
            v_n = v_q;
            r_n = r_q;
            d_n = d_q;
            p_n = p_q;
            t_n = t_q;
            if (clr_en_i && clr_idx_i == SI) begin
                r_n = 1'b0;
                t_n = now_i;
            end
            if (evict_en_i && evict_idx_i == SI) v_n = 1'b0;
            if (wbset_en_i && wbset_idx_i == SI) p_n = 1'b1;
            if (tick_i && r_q) t_n = now_i + 1'b1;
            if (wbdone_en_i && wbdone_idx_i == SI) begin
                d_n = 1'b0;
                p_n = 1'b0;
            end
            if (acc_en_i && acc_idx_i == SI && v_q) begin
                r_n = 1'b1;
                if (acc_wr_i) d_n = 1'b1;
            end
            if (ld_en_i && ld_idx_i == SI) begin
                v_n = 1'b1;
                r_n = 1'b0;
                d_n = 1'b0;
                p_n = 1'b0;
                t_n = now_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                r_q <= 1'b0;
                d_q <= 1'b0;
                p_q <= 1'b0;
                t_q <= '0;
            end else begin
                v_q <= v_n;
                r_q <= r_n;
                d_q <= d_n;
                p_q <= p_n;
                t_q <= t_n;
            end
        end

        assign valid_o[s] = v_q;
        assign ref_o[s]   = r_q;
        assign dirty_o[s] = d_q;
        assign pend_o[s]  = p_q;
        assign stamp_o[s] = t_q;
    end

    AST_LOAD_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en_i |=> valid_o[$past(ld_idx_i)] && !ref_o[$past(ld_idx_i)]
                    && !dirty_o[$past(ld_idx_i)]); // R2
    AST_WBDONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (wbdone_en_i && !(acc_en_i && acc_wr_i && acc_idx_i == wbdone_idx_i))
        |=> !dirty_o[$past(wbdone_idx_i)] && !pend_o[$past(wbdone_idx_i)]); // R11
endmodule

// File: rtl/wsc_sweep_fsm.sv
module wsc_sweep_fsm
    import wsc_pkg::*;
#(
    parameter int NSLOT  = 8,
    parameter int WB_CAP = 2,
    localparam int IDX_W  = $clog2(NSLOT),
    localparam int STEP_W = $clog2(NSLOT + 1),
    localparam int CNT_W  = $clog2(WB_CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evict_req_i,
    input  logic             wb_done_i,
    input  logic [IDX_W-1:0] wb_done_idx_i,
    input  logic [NSLOT-1:0] valid_i,
    input  logic [NSLOT-1:0] ref_i,
    input  logic [NSLOT-1:0] dirty_i,
    input  logic [NSLOT-1:0] pend_i,
    input  logic             hand_old_i,
    output logic [IDX_W-1:0] hand_o,
    output logic             victim_valid_o,
    output logic [IDX_W-1:0] victim_idx_o,
    output logic             wb_req_o,
    output logic             clr_en_o,
    output logic             busy_o
);
    sweep_state_e     state_q, state_d;
    logic [IDX_W-1:0] hand_q, hand_d;
    logic [STEP_W-1:0] steps_q, steps_d;
    logic [CNT_W-1:0] wbcnt_q, wbcnt_d;
    logic             adv;
    logic             h_valid, h_ref, h_dirty, h_pend;

    assign h_valid = valid_i[hand_q];
    assign h_ref   = ref_i[hand_q];
    assign h_dirty = dirty_i[hand_q];
    assign h_pend  = pend_i[hand_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hand_q  <= '0;
            steps_q <= '0;
            wbcnt_q <= '0;
        end else begin
            state_q <= state_d;
            hand_q  <= hand_d;
            steps_q <= steps_d;
            wbcnt_q <= wbcnt_d;
        end
    end

    always_comb begin
        state_d        = state_q;
        hand_d         = hand_q;
        steps_d        = steps_q;
        wbcnt_d        = wbcnt_q;
        victim_valid_o = 1'b0;
        victim_idx_o   = hand_q;
        wb_req_o       = 1'b0;
        clr_en_o       = 1'b0;
        adv            = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (evict_req_i) begin
                    state_d = ST_SCAN;
                    steps_d = '0;
                    wbcnt_d = '0;
                end
            end
            ST_SCAN: begin
                if (!h_valid) begin
                    victim_valid_o = 1'b1;
                end else if (h_ref) begin
                    clr_en_o = 1'b1;
                    adv      = 1'b1;
                end else if (hand_old_i && !h_dirty) begin
                    victim_valid_o = 1'b1;
                end else begin
                    adv = 1'b1;
                    if (hand_old_i && !h_pend && wbcnt_q < CNT_W'(WB_CAP)) begin
                        wb_req_o = 1'b1;
                        wbcnt_d  = wbcnt_q + 1'b1;
                    end
                end
                if (adv) begin
                    hand_d  = hand_q + 1'b1;
                    steps_d = steps_q + 1'b1;
                    if (steps_q == STEP_W'(NSLOT - 1)) state_d = ST_LOOP_END;
                end
            end
            ST_LOOP_END: begin
                if (wb_done_i) begin
                    victim_valid_o = 1'b1;
                    victim_idx_o   = wb_done_idx_i;
                end else if (|pend_i) begin
                    state_d = ST_WAIT_WB;
                end else begin
                    victim_valid_o = 1'b1;
                end
            end
            ST_WAIT_WB: begin
                if (wb_done_i) begin
                    victim_valid_o = 1'b1;
                    victim_idx_o   = wb_done_idx_i;
                end
            end
            default: ;
        endcase
        if (victim_valid_o) begin
            hand_d  = victim_idx_o + 1'b1;
            state_d = ST_IDLE;
        end
    end

    assign hand_o = hand_q;
    assign busy_o = state_q != ST_IDLE;

    AST_VICTIM_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid_o |-> state_q != ST_IDLE); // R6
    AST_VICTIM_HAND_PAST: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid_o |=> state_q == ST_IDLE
                           && hand_q == IDX_W'($past(victim_idx_o) + 1'b1)); // R6
    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && !victim_valid_o) |=> hand_q == IDX_W'($past(hand_q) + 1'b1)); // R5
    AST_WB_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        wbcnt_q <= CNT_W'(WB_CAP)); // R8
    AST_WB_ONLY_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req_o |-> state_q == ST_SCAN && !victim_valid_o); // R8
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SCAN |-> steps_q < STEP_W'(NSLOT)); // R9
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_WB && !wb_done_i) |=> state_q == ST_WAIT_WB); // R10
    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && evict_req_i && !victim_valid_o)
        |=> state_q != ST_IDLE); // R12
endmodule

// File: rtl/wsclock_victim_sel.sv
module wsclock_victim_sel #(
    parameter int NSLOT  = 8,
    parameter int TS_W   = 16,
    parameter int TAU    = 4,
    parameter int WB_CAP = 2,
    localparam int IDX_W = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_en_i,
    input  logic [IDX_W-1:0] load_idx_i,
    input  logic             acc_en_i,
    input  logic [IDX_W-1:0] acc_idx_i,
    input  logic             acc_wr_i,
    input  logic             evict_req_i,
    input  logic             wb_done_i,
    input  logic [IDX_W-1:0] wb_done_idx_i,
    output logic             victim_valid_o,
    output logic [IDX_W-1:0] victim_idx_o,
    output logic             wb_req_o,
    output logic [IDX_W-1:0] wb_idx_o,
    output logic             busy_o
);
    logic [NSLOT-1:0]           valid, refd, dirty, pend;
    logic [NSLOT-1:0][TS_W-1:0] stamps;
    logic [TS_W-1:0]            now;
    logic [IDX_W-1:0]           hand;
    logic                       hand_old;
    logic                       clr_en;

    wsc_timebase #(.TS_W(TS_W), .TAU(TAU)) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .stamp_i (stamps[hand]),
        .now_o   (now),
        .old_o   (hand_old)
    );

    wsc_slot_array #(.NSLOT(NSLOT), .TS_W(TS_W)) u_slots (
        .clk          (clk),
        .rst_n        (rst_n),
        .now_i        (now),
        .tick_i       (tick_i),
        .ld_en_i      (load_en_i),
        .ld_idx_i     (load_idx_i),
        .acc_en_i     (acc_en_i),
        .acc_idx_i    (acc_idx_i),
        .acc_wr_i     (acc_wr_i),
        .clr_en_i     (clr_en),
        .clr_idx_i    (hand),
        .evict_en_i   (victim_valid_o),
        .evict_idx_i  (victim_idx_o),
        .wbset_en_i   (wb_req_o),
        .wbset_idx_i  (hand),
        .wbdone_en_i  (wb_done_i),
        .wbdone_idx_i (wb_done_idx_i),
        .valid_o      (valid),
        .ref_o        (refd),
        .dirty_o      (dirty),
        .pend_o       (pend),
        .stamp_o      (stamps)
    );

    wsc_sweep_fsm #(.NSLOT(NSLOT), .WB_CAP(WB_CAP)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .evict_req_i    (evict_req_i),
        .wb_done_i      (wb_done_i),
        .wb_done_idx_i  (wb_done_idx_i),
        .valid_i        (valid),
        .ref_i          (refd),
        .dirty_i        (dirty),
        .pend_i         (pend),
        .hand_old_i     (hand_old),
        .hand_o         (hand),
        .victim_valid_o (victim_valid_o),
        .victim_idx_o   (victim_idx_o),
        .wb_req_o       (wb_req_o),
        .clr_en_o       (clr_en),
        .busy_o         (busy_o)
    );

    assign wb_idx_o = hand;
endmodule

// File: tb/wsclock_victim_sel_bench.sv
module wsclock_victim_sel_bench;
    localparam int NS = 8, TAU = 4, CAP = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       tick = 0, load_en = 0, acc_en = 0, acc_wr = 0, evict_req = 0, wb_done = 0;
    logic [2:0] load_idx = 0, acc_idx = 0, wb_done_idx = 0;
    logic       victim_valid, wb_req, busy;
    logic [2:0] victim_idx, wb_idx;

    wsclock_victim_sel u_wsclock_victim_sel (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .load_en_i(load_en), .load_idx_i(load_idx),
        .acc_en_i(acc_en), .acc_idx_i(acc_idx), .acc_wr_i(acc_wr),
        .evict_req_i(evict_req), .wb_done_i(wb_done), .wb_done_idx_i(wb_done_idx),
        .victim_valid_o(victim_valid), .victim_idx_o(victim_idx),
        .wb_req_o(wb_req), .wb_idx_o(wb_idx), .busy_o(busy)
    );

    int checks = 0, failures = 0;
    bit done_flag = 0;

    // behavioural model: 0 idle, 1 scanning, 2 lap finished, 3 waiting on write-back
    bit mv[NS], mr[NS], md[NS], mp[NS];
    int mt[NS];
    int mnow = 0, mhand = 0, mstate = 0, msteps = 0, mwb = 0, since_rst = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        int  h = mhand;
        int  age = (mnow - mt[h]) & 32'hFFFF;
        bit  old = age > TAU;
        bit  ev = 0, wb = 0, clr = 0, adv = 0, anyp = 0;
        int  evi = mhand;
        bit  oldr[NS];
        string tag;
        for (int i = 0; i < NS; i++) anyp |= mp[i];
        tag = (since_rst == 0) ? "R1" : (tick ? "R3" : "R2");
        case (mstate)
            0: begin
                if (wb_done) tag = "R11";
                if (evict_req) begin mstate = 1; msteps = 0; mwb = 0; end
            end
            1: begin
                if (evict_req) tag = "R12";
                if (!mv[h]) begin ev = 1; tag = "R4"; end
                else if (mr[h]) begin clr = 1; adv = 1; tag = "R5"; end
                else if (old && !md[h]) begin ev = 1; tag = "R6"; end
                else begin
                    adv = 1;
                    tag = old ? "R8" : "R7";
                    if (old && !mp[h] && mwb < CAP) begin wb = 1; mwb++; end
                end
                if (adv) begin
                    mhand = (mhand + 1) % NS;
                    msteps++;
                    if (msteps == NS) mstate = 2;
                end
            end
            2: begin
                if (wb_done) begin ev = 1; evi = wb_done_idx; tag = "R10"; end
                else if (anyp) begin mstate = 3; tag = "R10"; end
                else begin ev = 1; tag = "R9"; end
            end
            default: begin
                tag = evict_req ? "R12" : "R10";
                if (wb_done) begin ev = 1; evi = wb_done_idx; end
            end
        endcase
        chk(busy === (mstate_prev() != 0), tag, "busy", busy, mstate_prev() != 0);
        chk(victim_valid === ev, tag, "victim_valid", victim_valid, ev);
        if (ev) chk(victim_idx === 3'(evi), tag, "victim_idx", victim_idx, evi);
        chk(wb_req === wb, tag, "wb_req", wb_req, wb);
        if (wb) chk(wb_idx === 3'(h), tag, "wb_idx", wb_idx, h);
        if (ev) begin mhand = (evi + 1) % NS; mstate = 0; end
        // slot updates in the stated order
        for (int i = 0; i < NS; i++) oldr[i] = mr[i];
        if (clr) begin mr[h] = 0; mt[h] = mnow; end
        if (ev) mv[evi] = 0;
        if (wb) mp[h] = 1;
        if (tick) for (int i = 0; i < NS; i++) if (oldr[i]) mt[i] = (mnow + 1) & 32'hFFFF;
        if (wb_done) begin md[wb_done_idx] = 0; mp[wb_done_idx] = 0; end
        if (acc_en && mv[acc_idx] && oldr_valid(acc_idx)) begin
            mr[acc_idx] = 1;
            if (acc_wr) md[acc_idx] = 1;
        end
        if (load_en) begin
            mv[load_idx] = 1; mr[load_idx] = 0; md[load_idx] = 0; mp[load_idx] = 0;
            mt[load_idx] = mnow;
        end
        if (tick) mnow = (mnow + 1) & 32'hFFFF;
        since_rst++;
        prev_state = mstate;
        prev_valid_snapshot();
    endtask

    // state and validity as seen before the current update
    int prev_state = 0;
    bit pv[NS];
    function automatic int mstate_prev();
        return prev_state;
    endfunction
    function automatic bit oldr_valid(int i);
        return pv[i];
    endfunction
    task automatic prev_valid_snapshot();
        for (int i = 0; i < NS; i++) pv[i] = mv[i];
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n && !done_flag) model_step();
    end

    task automatic idle_cyc(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic do_load(int i);
        @(negedge clk); load_en = 1; load_idx = 3'(i);
        @(negedge clk); load_en = 0;
    endtask
    task automatic do_acc(int i, bit w);
        @(negedge clk); acc_en = 1; acc_idx = 3'(i); acc_wr = w;
        @(negedge clk); acc_en = 0; acc_wr = 0;
    endtask
    task automatic do_ticks(int n);
        repeat (n) begin @(negedge clk); tick = 1; @(negedge clk); tick = 0; end
    endtask
    task automatic do_wbdone(int i);
        @(negedge clk); wb_done = 1; wb_done_idx = 3'(i);
        @(negedge clk); wb_done = 0;
    endtask
    task automatic do_evict();
        @(negedge clk); evict_req = 1;
        @(negedge clk); evict_req = 0;
        while (busy) @(negedge clk);
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog run did not end");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NS; i++) begin mv[i] = 0; mr[i] = 0; md[i] = 0; mp[i] = 0; mt[i] = 0; end
        repeat (4) @(negedge clk);
        chk(busy === 1'b0 && victim_valid === 1'b0 && wb_req === 1'b0, "R1", "reset outputs",
            {busy, victim_valid, wb_req}, 0);
        rst_n = 1;
        idle_cyc(2);
        // R4: empty ring yields slot 0
        do_evict();
        for (int i = 0; i < NS; i++) do_load(i);
        do_acc(1, 0); do_acc(2, 0); do_acc(3, 1);
        do_ticks(6);
        // R5, R6: referenced slots skipped, first old clean one chosen
        do_evict();
        do_load(4);
        for (int i = 5; i < 8; i++) do_acc(i, 1);
        do_acc(0, 1);
        // R7, R9: nothing old, nothing pending -> hand slot
        do_evict();
        do_load(5);
        do_ticks(6);
        // R8: dirty old slots request write-backs up to the cap
        do_evict();
        do_wbdone(6); do_wbdone(7);   // R11
        do_load(1);
        for (int i = 1; i < 8; i++) if (i != 3) do_acc(i, 0);
        do_ticks(1);
        // R10, R12: lap ends with pending write-backs, wait, extra request ignored
        @(negedge clk); evict_req = 1;
        @(negedge clk); evict_req = 0;
        repeat (14) @(negedge clk);
        @(negedge clk); evict_req = 1;
        @(negedge clk); evict_req = 0;
        do_wbdone(3);
        while (busy) @(negedge clk);
        do_wbdone(0);
        do_evict();
        // mixed traffic
        for (int n = 0; n < 400; n++) begin
            int r = $urandom_range(0, 9);
            @(negedge clk);
            tick = ($urandom_range(0, 3) == 0);
            acc_en = (r < 4); acc_idx = 3'($urandom_range(0, 7)); acc_wr = $urandom_range(0, 1) == 1;
            load_en = (r == 5); load_idx = 3'($urandom_range(0, 7));
            evict_req = (r == 6);
            wb_done = (r == 7) || (mstate == 3 && $urandom_range(0, 2) == 0);
            wb_done_idx = 3'($urandom_range(0, 7));
            for (int i = 0; i < NS; i++) if (mp[i] && wb_done) wb_done_idx = 3'(i);
        end
        @(negedge clk);
        tick = 0; acc_en = 0; load_en = 0; evict_req = 0; wb_done = 0;
        while (busy) begin
            @(negedge clk); wb_done = 1; @(negedge clk); wb_done = 0;
        end
        idle_cyc(3);
        finish_run();
    end
endmodule